// File: doc/BRIEF.md
# Fully Associative Write-Back Line Cache

This block sits between a processor port and a line-wide memory port. It holds a configurable number of lines of four 32-bit words each, and any line can hold any address. A processor request names an operation (fetch, store or flush), a word address, store data, the requester's view of the current cycle count and a user-mode flag. Each request gets back exactly one response with read data, a trap code and the number of stall cycles that the access cost. The handshake holds the next request off until those stall cycles have passed.

A hit is served from the line store at once. A miss picks its victim with a rotating pointer. If the victim line is dirty it is written back first, then the new line is read in. The stall charged on a miss is built from fixed stages and from a shared bus-busy time, so that back-to-back misses queue behind each other. A per-line read-only flag, which memory supplies with each refill, and a kernel address limit produce access faults on stores. A flush writes every dirty line back.

Top module: `fa_wb_cache`

## Requirements
- R1: The word in a line is picked by address bits [1:0]. The line address is the request address with those two bits cleared, and it is the address used on both memory ports.
- R2: A fetch or store that hits responds on the second rising edge after acceptance, with stall 0, and creates no memory traffic. Its trap code is 0 (none) unless a store fault applies.
- R3: The victim pointer starts at line 0 after reset. It advances by one after every successful refill and wraps to 0 after the last line.
- R4: A hit on the line the victim pointer designates also advances the pointer by one, with the same wrap.
- R5: The stall of a miss is the bus-busy remainder plus 3, plus 6 if the victim is dirty, plus 4. The remainder is busy minus request cycle when busy is later than the request cycle, and 0 otherwise, capped at 10000. The bus-busy time afterwards is max(busy, request cycle) + 3 (+6 if the victim is dirty) + 4 + 3.
- R6: A dirty victim has its four words written back to its own line address before the refill read, and its dirty flag is then clear. A clean victim causes no write.
- R7: A user-mode store to an address below the kernel limit (parameter, default 0x1000) returns trap 2 (access fault) and data 0, and leaves the line unchanged.
- R8: A store to a line that memory marked read-only returns the old word with trap 2, and leaves the line unchanged.
- R9: A store without a fault returns the old word with trap 0, writes the new word and marks the line dirty.
- R10: When memory reports that no page backs a refill, the response is trap 1 (map fault), data 0 and stall 3. The victim line is then invalid, the pointer does not advance, and the bus-busy time becomes max(busy, cycle) + 3.
- R11: A flush writes each dirty line back once, in ascending line order, and then clears its dirty flag. It responds with data 0, trap 0 and stall 0, and does not change the bus-busy time.
- R12: Request ready is low from acceptance until the single-cycle response. The response comes no earlier than the reported stall count of cycles after acceptance.
- R13: After reset the request port is ready, no response is pending, no line is valid and the bus-busy time is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 2 | 0 fetch, 1 store, 2 flush |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_cycle | input | CW | Requester's cycle count |
| req_user | input | 1 | User-mode request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Fetched word or old word |
| rsp_trap | output | 2 | 0 none, 1 map fault, 2 access fault |
| rsp_stall | output | SW | Stall cycles charged |
| mem_rd_req | output | 1 | Line read request, held until ack |
| mem_rd_addr | output | AW | Line address to read |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_line | input | WPL*DW | Line data, word 0 in low bits |
| mem_rd_nopage | input | 1 | No backing page for this read |
| mem_rd_ro | input | 1 | Line is read-only |
| mem_wr_req | output | 1 | Line write request, held until ack |
| mem_wr_addr | output | AW | Line address to write |
| mem_wr_line | output | WPL*DW | Line data to write |
| mem_wr_ack | input | 1 | Write taken |

## Verification
The bench drives the pointer around a four-line cache. A hit on the victim line must advance the pointer. A design that skips this advance would evict a line that is still in use: a later fetch of it would miss and report stall 7, or stall 13 if that line was dirty. A request made earlier than the pending bus-busy time must pay the remainder, and a request far earlier must be capped at 10000. A design that drops or mis-caps the remainder returns a wrong stall. After a map fault, a refetch of the line that was invalidated must miss, and the following evictions must fall in the same order. A stale valid flag or a pointer that stepped would show as a hit or a wrong eviction. Stores are checked for the access fault under the kernel limit, the fault on a read-only line, and the value that comes back through a dirty write-back and a refill. The write-back count of a second flush is checked to be zero.

// File: rtl/fa_cache_pkg.sv
// Shared constants and state type for the fully associative write-back cache.
// Assumes: cost figures are fixed stage costs in cycles.
package fa_cache_pkg;
    localparam logic [1:0] OP_FETCH = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_FLUSH = 2'd2;

    localparam logic [1:0] TRAP_NONE   = 2'd0;
    localparam logic [1:0] TRAP_MAP    = 2'd1;
    localparam logic [1:0] TRAP_ACCESS = 2'd2;

    localparam int unsigned COST_ARB   = 3;
    localparam int unsigned COST_WB    = 6;
    localparam int unsigned COST_FIRST = 4;
    localparam int unsigned COST_TAIL  = 3;
    localparam int unsigned COST_MAP   = 3;
    localparam int unsigned BUSY_CAP   = 10000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOK, ST_WB, ST_FILL, ST_FSCAN, ST_FWB, ST_HOLD, ST_RESP
    } cache_state_e;
endpackage

// File: rtl/fa_cache_match.sv
// Parallel tag compare over all lines; lowest matching index wins.
// Assumes: at most one valid line holds a given tag in normal use.
module fa_cache_match #(
    parameter int NLINES = 64,
    parameter int TAGW   = 30
) (
    input  logic [TAGW-1:0]   tags [NLINES],
    input  logic [NLINES-1:0] valid,
    input  logic [TAGW-1:0]   key,
    output logic              hit,
    output logic [((NLINES > 1) ? $clog2(NLINES) : 1)-1:0] idx
);
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic [NLINES-1:0] match;

    for (genvar g = 0; g < NLINES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    // Encode the matching line index.
    always_comb begin
        idx = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/fa_cache_victim.sv
// Rotating replacement pointer; steps by one on adv and wraps after the last line.
// Assumes: adv is a single-cycle strobe from the controller.
module fa_cache_victim #(
    parameter int NLINES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic [((NLINES > 1) ? $clog2(NLINES) : 1)-1:0] idx
);
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;
    localparam logic [IW-1:0] LAST = IW'(NLINES - 1);

    // Step the pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx <= '0;
        else if (adv)        idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/fa_cache_cost.sv
// Miss cost before refill: capped bus-busy remainder plus arbitration and
// optional write-back, and the bus-busy base those stages leave behind.
// Assumes: busy and cycle are unsigned counts on the same time base.
module fa_cache_cost #(
    parameter int CW = 32,
    parameter int SW = 16
) (
    input  logic [CW-1:0] busy,
    input  logic [CW-1:0] cyc,
    input  logic          wb_needed,
    output logic [SW-1:0] stall_pre,
    output logic [CW-1:0] busy_base
);
    import fa_cache_pkg::*;

    logic [CW-1:0] rem;
    logic [CW-1:0] capped;
    logic [CW-1:0] start;
    logic [SW-1:0] extra;

    // Remainder, cap and stage sums.
    always_comb begin
        rem       = (busy > cyc) ? (busy - cyc) : '0;
        capped    = (rem > CW'(BUSY_CAP)) ? CW'(BUSY_CAP) : rem;
        start     = (busy > cyc) ? busy : cyc;
        extra     = SW'(COST_ARB) + (wb_needed ? SW'(COST_WB) : '0);
        stall_pre = SW'(capped) + extra;
        busy_base = start + CW'(extra);
    end
endmodule

// File: rtl/fa_wb_cache.sv
// Fully associative write-back cache controller with rotating victim,
// fixed-stage miss costs, store faults and flush.
// Assumes: memory holds rd/wr requests until ack; one request in flight.
module fa_wb_cache #(
    parameter int          NLINES = 64,
    parameter int          WPL    = 4,
    parameter int          DW     = 32,
    parameter int          AW     = 32,
    parameter int          CW     = 32,
    parameter int          SW     = 16,
    parameter int unsigned KLIMIT = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [CW-1:0]     req_cycle,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic [1:0]        rsp_trap,
    output logic [SW-1:0]     rsp_stall,
    output logic              mem_rd_req,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [WPL*DW-1:0] mem_rd_line,
    input  logic              mem_rd_nopage,
    input  logic              mem_rd_ro,
    output logic              mem_wr_req,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [WPL*DW-1:0] mem_wr_line,
    input  logic              mem_wr_ack
);
    import fa_cache_pkg::*;

    localparam int OFFW = $clog2(WPL);
    localparam int TAGW = AW - OFFW;
    localparam int IW   = (NLINES > 1) ? $clog2(NLINES) : 1;
    localparam int LW   = WPL * DW;
    localparam logic [IW-1:0] LAST_LINE = IW'(NLINES - 1);

    cache_state_e st;

    logic [1:0]        op_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [CW-1:0]     cycle_q;
    logic              user_q;

    logic [TAGW-1:0]   tag_q [NLINES];
    logic [LW-1:0]     data_q [NLINES];
    logic [NLINES-1:0] valid_q, dirty_q, ro_q;

    logic [CW-1:0]     busy_q, busy_base_q;
    logic [SW-1:0]     stall_acc_q, hold_q;
    logic [IW-1:0]     fl_idx;

    logic [DW-1:0]     rsp_data_q;
    logic [1:0]        rsp_trap_q;
    logic [SW-1:0]     rsp_stall_q;

    logic              hit;
    logic [IW-1:0]     hit_idx, vict;
    logic              vict_adv;
    logic              vict_dirty;
    logic [SW-1:0]     stall_pre;
    logic [CW-1:0]     busy_base_c;

    logic [LW-1:0]     src_line, merged;
    logic              src_ro;
    logic [DW-1:0]     old_word;
    logic              user_fault, ro_fault, store_ok;
    logic [DW-1:0]     res_data;
    logic [1:0]        res_trap;
    logic [IW-1:0]     wr_idx;
    logic              fill_ok;

    fa_cache_match #(.NLINES(NLINES), .TAGW(TAGW)) match_i (
        .tags (tag_q),
        .valid(valid_q),
        .key  (addr_q[AW-1:OFFW]),
        .hit  (hit),
        .idx  (hit_idx)
    );

    fa_cache_victim #(.NLINES(NLINES)) victim_i (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (vict_adv),
        .idx  (vict)
    );

    fa_cache_cost #(.CW(CW), .SW(SW)) cost_i (
        .busy     (busy_q),
        .cyc      (cycle_q),
        .wb_needed(vict_dirty),
        .stall_pre(stall_pre),
        .busy_base(busy_base_c)
    );

    assign vict_dirty = valid_q[vict] && dirty_q[vict];
    assign fill_ok    = (st == ST_FILL) && mem_rd_ack && !mem_rd_nopage;

    // Pointer steps after a refill or on a hit to the victim line.
    assign vict_adv = fill_ok ||
                      ((st == ST_LOOK) && (op_q != OP_FLUSH) && hit && (hit_idx == vict));

    // Apply the fetch or store to the line being served (hit or fresh refill).
    always_comb begin
        src_line   = (st == ST_FILL) ? mem_rd_line : data_q[hit_idx];
        src_ro     = (st == ST_FILL) ? mem_rd_ro   : ro_q[hit_idx];
        old_word   = src_line[addr_q[OFFW-1:0]*DW +: DW];
        user_fault = (op_q == OP_STORE) && user_q && (addr_q < AW'(KLIMIT));
        ro_fault   = (op_q == OP_STORE) && !user_fault && src_ro;
        store_ok   = (op_q == OP_STORE) && !user_fault && !src_ro;
        res_data   = user_fault ? '0 : old_word;
        res_trap   = (user_fault || ro_fault) ? TRAP_ACCESS : TRAP_NONE;
        merged     = src_line;
        if (store_ok) merged[addr_q[OFFW-1:0]*DW +: DW] = wdata_q;
    end

    // Control, flags and bookkeeping of the request sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            op_q        <= OP_FETCH;
            addr_q      <= '0;
            wdata_q     <= '0;
            cycle_q     <= '0;
            user_q      <= 1'b0;
            valid_q     <= '0;
            dirty_q     <= '0;
            ro_q        <= '0;
            busy_q      <= '0;
            busy_base_q <= '0;
            stall_acc_q <= '0;
            hold_q      <= '0;
            fl_idx      <= '0;
            rsp_data_q  <= '0;
            rsp_trap_q  <= TRAP_NONE;
            rsp_stall_q <= '0;
            for (int i = 0; i < NLINES; i++) tag_q[i] <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    op_q    <= req_op;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    cycle_q <= req_cycle;
                    user_q  <= req_user;
                    st      <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (op_q == OP_FLUSH) begin
                        fl_idx <= '0;
                        st     <= ST_FSCAN;
                    end else if (hit) begin
                        rsp_data_q  <= res_data;
                        rsp_trap_q  <= res_trap;
                        rsp_stall_q <= '0;
                        if (store_ok) dirty_q[hit_idx] <= 1'b1;
                        st <= ST_RESP;
                    end else begin
                        stall_acc_q <= stall_pre;
                        busy_base_q <= busy_base_c;
                        st          <= vict_dirty ? ST_WB : ST_FILL;
                    end
                end
                ST_WB: if (mem_wr_ack) begin
                    dirty_q[vict] <= 1'b0;
                    st            <= ST_FILL;
                end
                ST_FILL: if (mem_rd_ack) begin
                    if (mem_rd_nopage) begin
                        valid_q[vict] <= 1'b0;
                        busy_q        <= busy_base_q;
                        rsp_data_q    <= '0;
                        rsp_trap_q    <= TRAP_MAP;
                        rsp_stall_q   <= SW'(COST_MAP);
                        hold_q        <= SW'(COST_MAP);
                    end else begin
                        tag_q[vict]   <= addr_q[AW-1:OFFW];
                        valid_q[vict] <= 1'b1;
                        dirty_q[vict] <= store_ok;
                        ro_q[vict]    <= mem_rd_ro;
                        busy_q        <= busy_base_q + CW'(COST_FIRST + COST_TAIL);
                        rsp_data_q    <= res_data;
                        rsp_trap_q    <= res_trap;
                        rsp_stall_q   <= stall_acc_q + SW'(COST_FIRST);
                        hold_q        <= stall_acc_q + SW'(COST_FIRST);
                    end
                    st <= ST_HOLD;
                end
                ST_FSCAN: begin
                    if (valid_q[fl_idx] && dirty_q[fl_idx]) begin
                        st <= ST_FWB;
                    end else if (fl_idx == LAST_LINE) begin
                        rsp_data_q  <= '0;
                        rsp_trap_q  <= TRAP_NONE;
                        rsp_stall_q <= '0;
                        st          <= ST_RESP;
                    end else begin
                        fl_idx <= fl_idx + 1'b1;
                    end
                end
                ST_FWB: if (mem_wr_ack) begin
                    dirty_q[fl_idx] <= 1'b0;
                    if (fl_idx == LAST_LINE) begin
                        rsp_data_q  <= '0;
                        rsp_trap_q  <= TRAP_NONE;
                        rsp_stall_q <= '0;
                        st          <= ST_RESP;
                    end else begin
                        fl_idx <= fl_idx + 1'b1;
                        st     <= ST_FSCAN;
                    end
                end
                ST_HOLD: begin
                    if (hold_q == '0) st <= ST_RESP;
                    else              hold_q <= hold_q - 1'b1;
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Line data store: refill with merged store word, or store on hit.
    always_ff @(posedge clk) begin
        if (fill_ok)
            data_q[vict] <= merged;
        else if ((st == ST_LOOK) && (op_q != OP_FLUSH) && hit && store_ok)
            data_q[hit_idx] <= merged;
    end

    assign wr_idx      = (st == ST_WB) ? vict : fl_idx;
    assign mem_wr_req  = (st == ST_WB) || (st == ST_FWB);
    assign mem_wr_addr = {tag_q[wr_idx], {OFFW{1'b0}}};
    assign mem_wr_line = data_q[wr_idx];
    assign mem_rd_req  = (st == ST_FILL);
    assign mem_rd_addr = {addr_q[AW-1:OFFW], {OFFW{1'b0}}};

    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_RESP);
    assign rsp_data  = rsp_data_q;
    assign rsp_trap  = rsp_trap_q;
    assign rsp_stall = rsp_stall_q;
endmodule

// File: rtl/fa_wb_cache_chk.sv
// Port-level property checker for fa_wb_cache, attached by bind.
// Assumes: synchronous active-low reset held low from time zero.
module fa_wb_cache_chk #(
    parameter int          AW     = 32,
    parameter int          DW     = 32,
    parameter int          SW     = 16,
    parameter int unsigned KLIMIT = 32'h0000_1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic          req_user,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic [1:0]    rsp_trap,
    input logic [SW-1:0] rsp_stall,
    input logic          mem_rd_req,
    input logic          mem_wr_req,
    input logic          mem_wr_ack,
    input logic [AW-1:0] mem_wr_addr
);
    logic [SW-1:0] acc_cnt;
    logic [1:0]    l_op;
    logic [AW-1:0] l_addr;
    logic          l_user;

    // Track the accepted request and the cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            l_op    <= 2'd0;
            l_addr  <= '0;
            l_user  <= 1'b0;
        end else if (req_valid && req_ready) begin
            acc_cnt <= '0;
            l_op    <= req_op;
            l_addr  <= req_addr;
            l_user  <= req_user;
        end else if (acc_cnt != '1) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    assert_idle_after_reset_R13: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && req_ready);

    assert_rsp_after_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> acc_cnt >= rsp_stall);

    assert_not_ready_in_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_map_fault_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap == 2'd1) |-> (rsp_data == '0 && rsp_stall == SW'(3)));

    assert_stall_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_stall <= SW'(10016));

    assert_one_mem_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    assert_wr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)));

    assert_user_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && l_op == 2'd1 && l_user && l_addr < AW'(KLIMIT) && rsp_trap != 2'd1)
        |-> (rsp_trap == 2'd2 && rsp_data == '0));
endmodule

bind fa_wb_cache fa_wb_cache_chk #(.AW(AW), .DW(DW), .SW(SW), .KLIMIT(KLIMIT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_user   (req_user),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_trap   (rsp_trap),
    .rsp_stall  (rsp_stall),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .mem_wr_ack (mem_wr_ack),
    .mem_wr_addr(mem_wr_addr)
);

// File: tb/fa_wb_cache_tb_top.sv
// Scoreboard bench: driver pushes expected responses, monitor pops and compares.
module fa_wb_cache_tb_top;
    localparam int NL = 4;
    localparam int K_HIT = 0, K_MISS = 1, K_MISSD = 2, K_MAP = 3, K_FLUSH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [31:0]   req_addr = '0, req_wdata = '0, req_cycle = '0;
    logic          req_user = 1'b0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic [1:0]    rsp_trap;
    logic [15:0]   rsp_stall;
    logic          mem_rd_req, mem_wr_req;
    logic [31:0]   mem_rd_addr, mem_wr_addr;
    logic          mem_rd_ack = 1'b0, mem_rd_nopage = 1'b0, mem_rd_ro = 1'b0, mem_wr_ack = 1'b0;
    logic [127:0]  mem_rd_line = '0;
    logic [127:0]  mem_wr_line;

    fa_wb_cache #(.NLINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cycle(req_cycle), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_trap(rsp_trap), .rsp_stall(rsp_stall),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_line(mem_rd_line), .mem_rd_nopage(mem_rd_nopage), .mem_rd_ro(mem_rd_ro),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_line(mem_wr_line),
        .mem_wr_ack(mem_wr_ack)
    );

    always #4 clk = ~clk;

    int  nchk = 0, nfail = 0;
    longint cyc_cnt = 0, acc_time = 0;
    longint busy_m = 0;
    logic [31:0] ovl [logic [31:0]];
    logic [31:0] last_rd_addr = '0;
    int          rd_cnt = 0;
    logic [31:0] wb_addr_log [$];
    logic [127:0] wb_line_log [$];

    typedef struct {
        logic [31:0] data;
        logic [1:0]  trap;
        longint      stall;
        bit          is_hit;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic logic [31:0] memw(input logic [31:0] a);
        if (ovl.exists(a)) return ovl[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", r, act, expv);
        end
    endtask

    // Memory model: no page above 0xF0000000, read-only when bit 20 set.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req && !mem_rd_ack) begin
                mem_rd_ack    = 1'b1;
                mem_rd_nopage = (mem_rd_addr[31:28] == 4'hF);
                mem_rd_ro     = mem_rd_addr[20];
                for (int w = 0; w < 4; w++) mem_rd_line[w*32 +: 32] = memw(mem_rd_addr + 32'(w));
                last_rd_addr  = mem_rd_addr;
                rd_cnt++;
            end else begin
                mem_rd_ack = 1'b0;
            end
            if (mem_wr_req && !mem_wr_ack) begin
                mem_wr_ack = 1'b1;
                for (int w = 0; w < 4; w++) ovl[mem_wr_addr + 32'(w)] = mem_wr_line[w*32 +: 32];
                wb_addr_log.push_back(mem_wr_addr);
                wb_line_log.push_back(mem_wr_line);
            end else begin
                mem_wr_ack = 1'b0;
            end
        end
    end

    // Monitor: compares each response against the next expected item.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected response", 128'(rsp_data), 128'(0));
                end else begin
                    exp_t e;
                    longint lat;
                    e   = exp_q.pop_front();
                    lat = cyc_cnt - acc_time;
                    chk(rsp_data == e.data, {e.tag, " data"}, 128'(rsp_data), 128'(e.data));
                    chk(rsp_trap == e.trap, {e.tag, " trap"}, 128'(rsp_trap), 128'(e.trap));
                    chk(longint'(rsp_stall) == e.stall, {e.tag, " stall"}, 128'(rsp_stall), 128'(e.stall));
                    chk(lat >= e.stall, "R12 response before stall elapsed", 128'(lat), 128'(e.stall));
                    if (e.is_hit) chk(lat == 1, "R2 hit latency", 128'(lat), 128'(1));
                end
            end
        end
    end

    // Driver: computes the expected stall from the busy model and issues the request.
    task automatic do_req(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd,
                          input longint cy, input logic u, input logic [31:0] ed,
                          input logic [1:0] et, input int kind, input string tag);
        exp_t e;
        longint rem, start;
        rem   = (busy_m > cy) ? busy_m - cy : 0;
        if (rem > 10000) rem = 10000;
        start = (busy_m > cy) ? busy_m : cy;
        e.data = ed; e.trap = et; e.tag = tag; e.is_hit = (kind == K_HIT);
        case (kind)
            K_MISS:  begin e.stall = rem + 7;  busy_m = start + 10; end
            K_MISSD: begin e.stall = rem + 13; busy_m = start + 16; end
            K_MAP:   begin e.stall = 3;        busy_m = start + 3;  end
            default: e.stall = 0;
        endcase
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        req_cycle = 32'(cy); req_user = u;
        @(negedge clk);
        acc_time  = cyc_cnt;
        req_valid = 1'b0;
        chk(!req_ready, "R12 ready low after accept", 128'(req_ready), 128'(0));
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    function automatic logic [31:0] f(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int wbn;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_req && !mem_wr_req, "R13 reset state",
            128'({req_ready, rsp_valid, mem_rd_req, mem_wr_req}), 128'(4'b1000));

        // R13/R1: first access misses; refill uses the line address.
        do_req(2'd0, 32'h2001, 0, 100, 0, f(32'h2001), 2'd0, K_MISS, "R13 R1 first fetch miss");
        chk(last_rd_addr == 32'h2000, "R1 refill line address", 128'(last_rd_addr), 128'(32'h2000));
        do_req(2'd0, 32'h2003, 0, 200, 0, f(32'h2003), 2'd0, K_HIT, "R1 R2 word select hit");
        chk(rd_cnt == 1, "R2 hit causes no read", 128'(rd_cnt), 128'(1));
        // R9: store returns old word and updates.
        do_req(2'd1, 32'h2002, 32'hDEAD0001, 210, 1, f(32'h2002), 2'd0, K_HIT, "R9 store old word");
        do_req(2'd0, 32'h2002, 0, 220, 0, 32'hDEAD0001, 2'd0, K_HIT, "R9 stored word reads back");
        // R5: remainder of bus-busy time.
        do_req(2'd0, 32'h3000, 0, 300, 0, f(32'h3000), 2'd0, K_MISS, "R3 fill line1");
        do_req(2'd0, 32'h4000, 0, 305, 0, f(32'h4000), 2'd0, K_MISS, "R5 busy remainder");
        do_req(2'd0, 32'h5000, 0, 1000, 0, f(32'h5000), 2'd0, K_MISS, "R3 fill line3");
        // R4: hit on victim line0 advances pointer, so line1 is evicted next.
        do_req(2'd0, 32'h2000, 0, 1100, 0, f(32'h2000), 2'd0, K_HIT, "R4 hit on victim");
        do_req(2'd0, 32'h6000, 0, 2000, 0, f(32'h6000), 2'd0, K_MISS, "R4 clean evict of line1");
        do_req(2'd0, 32'h2001, 0, 2100, 0, f(32'h2001), 2'd0, K_HIT, "R4 dirty line kept");
        do_req(2'd0, 32'h3000, 0, 3000, 0, f(32'h3000), 2'd0, K_MISS, "R3 evicted line misses");
        chk(wb_addr_log.size() == 0, "R6 no write for clean victims", 128'(wb_addr_log.size()), 128'(0));
        // R7: user store below kernel limit.
        do_req(2'd1, 32'h0800, 32'h1111, 4000, 1, 32'h0, 2'd2, K_MISS, "R7 user store below limit");
        do_req(2'd0, 32'h0800, 0, 4100, 0, f(32'h0800), 2'd0, K_HIT, "R7 line unchanged");
        // R3 wrap + R6: pointer wrapped to line0 which is dirty.
        do_req(2'd0, 32'h7000, 0, 5000, 0, f(32'h7000), 2'd0, K_MISSD, "R3 R6 dirty evict after wrap");
        chk(wb_addr_log.size() == 1, "R6 one write-back", 128'(wb_addr_log.size()), 128'(1));
        if (wb_addr_log.size() == 1) begin
            chk(wb_addr_log[0] == 32'h2000, "R6 write-back address", 128'(wb_addr_log[0]), 128'(32'h2000));
            chk(wb_line_log[0][95:64] == 32'hDEAD0001, "R6 write-back data",
                128'(wb_line_log[0][95:64]), 128'(32'hDEAD0001));
        end
        do_req(2'd0, 32'h2002, 0, 6000, 0, 32'hDEAD0001, 2'd0, K_MISS, "R6 refill sees written data");
        // R8: read-only line.
        do_req(2'd0, 32'h0010_0000, 0, 7000, 0, f(32'h0010_0000), 2'd0, K_MISS, "R8 fill read-only line");
        do_req(2'd1, 32'h0010_0001, 32'h1234, 7100, 0, f(32'h0010_0001), 2'd2, K_HIT, "R8 store to read-only");
        do_req(2'd0, 32'h0010_0001, 0, 7200, 0, f(32'h0010_0001), 2'd0, K_HIT, "R8 line unchanged");
        // R10: map fault invalidates victim line3 without stepping.
        do_req(2'd0, 32'hF000_0000, 0, 8000, 0, 32'h0, 2'd1, K_MAP, "R10 map fault");
        do_req(2'd0, 32'h0800, 0, 9000, 0, f(32'h0800), 2'd0, K_MISS, "R10 victim invalidated");
        // R11: flush writes both dirty lines in order.
        do_req(2'd1, 32'h7001, 32'hBEEF, 9100, 0, f(32'h7001), 2'd0, K_HIT, "R9 store line0");
        do_req(2'd1, 32'h2003, 32'hCAFE, 9200, 0, f(32'h2003), 2'd0, K_HIT, "R9 store line1");
        wbn = wb_addr_log.size();
        do_req(2'd2, 32'h0, 0, 9300, 0, 32'h0, 2'd0, K_FLUSH, "R11 flush");
        chk(wb_addr_log.size() == wbn + 2, "R11 flush write count", 128'(wb_addr_log.size() - wbn), 128'(2));
        if (wb_addr_log.size() == wbn + 2) begin
            chk(wb_addr_log[wbn] == 32'h7000, "R11 first flush address", 128'(wb_addr_log[wbn]), 128'(32'h7000));
            chk(wb_addr_log[wbn+1] == 32'h2000, "R11 second flush address", 128'(wb_addr_log[wbn+1]), 128'(32'h2000));
            chk(wb_line_log[wbn][63:32] == 32'hBEEF, "R11 flush data", 128'(wb_line_log[wbn][63:32]), 128'(32'hBEEF));
        end
        wbn = wb_addr_log.size();
        do_req(2'd2, 32'h0, 0, 9400, 0, 32'h0, 2'd0, K_FLUSH, "R11 second flush");
        chk(wb_addr_log.size() == wbn, "R11 second flush writes nothing", 128'(wb_addr_log.size() - wbn), 128'(0));
        do_req(2'd0, 32'h7001, 0, 9500, 0, 32'hBEEF, 2'd0, K_HIT, "R11 data kept after flush");
        // R5: cap on the remainder; flushes did not move busy time.
        do_req(2'd0, 32'h8000, 0, 20000, 0, f(32'h8000), 2'd0, K_MISS, "R5 R11 clean miss after flush");
        do_req(2'd0, 32'h9000, 0, 5, 0, f(32'h9000), 2'd0, K_MISS, "R5 remainder cap");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule